// File: doc/BRIEF.md
# BPSK Character Deframer with Stretchable Stop Bit

This block turns a stream of hard-decided phase samples into bytes. Upstream logic supplies the sign of the demodulated subcarrier twice per subcarrier cycle, so one symbol spans 32 samples. A separate start-of-frame detector pulses `sof_pulse` on a sample that carries the logic-0 phase. The block stores that phase as its reference. From then on, a sample that matches the reference means 0 and an inverted sample means 1.

Characters are framed like a UART word. There is a 0 start bit, then eight data bits least significant first, then a 1 stop bit. The transmitter may hold the stop level for up to 64 more samples before the next start bit, and the receiver cannot know this delay in advance. The block therefore does not run its symbol timing freely. It restarts its sample counter on the first reference-phase sample after a logic-1 stretch. Each bit is decided by a majority vote over the middle half of its samples.

The controller is a six-state machine:
- ST_IDLE waits for a start-of-frame pulse.
- ST_ARMED waits for the first logic-1 sample.
- ST_GUARD counts logic-1 samples and watches for the start edge.
- ST_START, ST_DATA and ST_STOP each collect whole symbols.

Transitions:
- A pulse on `sof_pulse` with a valid sample moves any state to ST_ARMED.
- ST_ARMED moves to ST_GUARD on a logic-1 sample.
- ST_GUARD moves to ST_START on a logic-0 sample. It moves to ST_IDLE with an error when the logic-1 run grows too long.
- ST_START moves to ST_DATA when the start bit is confirmed. It moves back to ST_GUARD when the start bit is rejected as a glitch.
- ST_DATA moves to ST_STOP after the eighth bit.
- ST_STOP moves to ST_GUARD after a good stop bit. It moves to ST_IDLE with an error after a bad one.

Top module: `bpsk_char_deframer`

## Requirements
- R1: After synchronous reset, `data_valid`, `framing_error` and `data_out` are all 0. Samples that arrive before the first start-of-frame pulse produce no output.
- R2: On a cycle where `sof_pulse` and `sample_valid` are both 1, `sample_sign` becomes the logic-0 reference. Later samples equal to it decode as 0 and inverted samples decode as 1. Both reference polarities work. A `sof_pulse` with `sample_valid` low has no effect.
- R3: A character is a 0 start bit, data bits 0 to 7 in that order, and a 1 stop bit. `data_out` takes the byte, and `data_valid` pulses for exactly one cycle per character, in the cycle after the last stop-bit sample. `data_out` changes only together with `data_valid`.
- R4: A symbol is 32 valid samples, numbered 0 to 31 from its first sample. The bit is 1 when more than 8 of samples 8..23 decode as 1, and 0 otherwise (so exactly 8 gives 0). Samples 0..7 and 24..31 never affect the decision.
- R5: In ST_GUARD, the first logic-0 sample becomes sample 0 of the start bit, so timing is re-aligned on every character.
- R6: A logic-1 run of up to 96 valid samples, counted from the first stop-bit sample (a guard time of 0 to 64 samples), is accepted and the next character decodes correctly.
- R7: On the 97th consecutive logic-1 sample, `framing_error` pulses for one cycle. The block then ignores samples until the next start-of-frame pulse.
- R8: A stop bit that decodes as 0 pulses `framing_error` for one cycle and produces no `data_valid`. The block then ignores samples until the next start-of-frame pulse.
- R9: A start bit whose vote gives 1 emits nothing. The block returns to ST_GUARD with its logic-1 count cleared.
- R10: Cycles with `sample_valid` low are ignored entirely: their sign does not count and symbol timing does not advance.
- R11: After a start-of-frame pulse, logic-0 samples are ignored until the first logic-1 sample is seen.
- R12: `framing_error` and `data_valid` are never high in the same cycle, and each stays high for only one cycle.
- R13: A start-of-frame pulse in any state drops any partly received character, loads the new reference and re-arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | `sample_sign` carries a new sample this cycle |
| sample_sign | input | 1 | Hard-decided subcarrier phase sample |
| sof_pulse | input | 1 | Start of frame; the current sample is the logic-0 phase |
| data_out | output | 8 | Last received byte |
| data_valid | output | 1 | One-cycle strobe for each received byte |
| framing_error | output | 1 | One-cycle strobe on a bad stop bit or an over-long logic-1 run |

## Verification
The bench sends both the shortest guard time (none) and the longest (64 samples). It then sends a run exactly one sample past the limit. A design with an off-by-one limit would either reject the legal maximum or accept 97 samples.

Vote tie tests place exactly 8 and then 9 ones inside the window, with opposing values outside it. A design with a wrong threshold or window would flip those bits.

Other directed cases:
- A one-sample dip to logic 0 in the guard, and logic-0 samples right after the start-of-frame pulse. A design lacking glitch rejection or the armed wait would emit a garbage byte.
- Interleaved invalid cycles, which carry inverted signs and a dummy start-of-frame pulse. These catch timing that advances on invalid cycles.
- A start-of-frame pulse in the middle of a character. This catches designs that fail to drop the partial byte.

// File: rtl/bpsk_deframer_pkg.sv
package bpsk_deframer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_GUARD,
        ST_START,
        ST_DATA,
        ST_STOP
    } dfr_state_t;

endpackage

// File: rtl/bpsk_phase_ref.sv
// Holds the logic-0 phase and maps raw signs to logic levels.
module bpsk_phase_ref (
    input  logic clk,
    input  logic rst,
    input  logic sample_valid,
    input  logic sample_sign,
    input  logic sof_pulse,
    output logic logic_bit
);

    logic ref_sign;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_sign <= 1'b0;
        end else if (sof_pulse && sample_valid) begin
            ref_sign <= sample_sign;
        end
    end

    // Equal to the reference -> 0, inverted -> 1
    assign logic_bit = sample_sign ^ ref_sign;

endmodule

// File: rtl/bpsk_symbol_voter.sv
// Counts samples inside one symbol and takes a majority vote over a window.
module bpsk_symbol_voter #(
    parameter int SYM_SAMPLES = 32,
    parameter int WIN_LO      = 8,
    parameter int WIN_LEN     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,   // current sample is index 0 of a new symbol
    input  logic advance,   // current sample belongs to the running symbol
    input  logic bit_in,
    output logic sym_done,  // current sample closes the symbol
    output logic sym_bit    // decision for the symbol closing now
);

    localparam int IDX_W  = $clog2(SYM_SAMPLES);
    localparam int WIN_HI = WIN_LO + WIN_LEN - 1;
    localparam int VOTE_W = $clog2(WIN_LEN + 1);
    localparam int LAST   = SYM_SAMPLES - 1;

    logic [IDX_W-1:0]  idx;
    logic [VOTE_W-1:0] votes;
    logic              in_win;
    logic [VOTE_W-1:0] votes_now;

    assign in_win    = (idx >= IDX_W'(WIN_LO)) && (idx <= IDX_W'(WIN_HI));
    assign votes_now = votes + VOTE_W'(in_win && bit_in);
    assign sym_done  = advance && (idx == IDX_W'(LAST));
    assign sym_bit   = votes_now > VOTE_W'(WIN_LEN / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            votes <= '0;
        end else if (restart) begin
            idx   <= IDX_W'(1);
            votes <= VOTE_W'((WIN_LO == 0) && bit_in);
        end else if (advance) begin
            if (idx == IDX_W'(LAST)) begin
                idx   <= '0;
                votes <= '0;
            end else begin
                idx   <= idx + IDX_W'(1);
                votes <= votes_now;
            end
        end
    end

endmodule

// File: rtl/bpsk_char_shifter.sv
// Assembles data bits, least significant first.
module bpsk_char_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word,
    output logic             last_bit
);

    localparam int CNT_W = $clog2(WIDTH);

    logic [CNT_W-1:0] cnt;

    assign last_bit = (cnt == CNT_W'(WIDTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            word <= '0;
        end else if (clear) begin
            cnt  <= '0;
        end else if (shift_en) begin
            cnt  <= cnt + CNT_W'(1);
            word <= {bit_in, word[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/bpsk_char_deframer.sv
module bpsk_char_deframer
    import bpsk_deframer_pkg::*;
#(
    parameter int SYM_SAMPLES       = 32,
    parameter int VOTE_LO           = 8,
    parameter int VOTE_LEN          = 16,
    parameter int GUARD_MAX_SAMPLES = 64,
    parameter int DATA_BITS         = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic                 sample_sign,
    input  logic                 sof_pulse,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 data_valid,
    output logic                 framing_error
);

    localparam int ONES_LIMIT = SYM_SAMPLES + GUARD_MAX_SAMPLES;
    localparam int ONES_W     = $clog2(ONES_LIMIT + 1);

    dfr_state_t state;
    dfr_state_t state_nxt;

    logic                 logic_bit;
    logic                 take;
    logic                 resync;
    logic                 start_edge;
    logic                 sym_adv;
    logic                 sym_done;
    logic                 sym_bit;
    logic                 shift_en;
    logic                 last_bit;
    logic [DATA_BITS-1:0] word;
    logic [ONES_W-1:0]    ones_cnt;
    logic                 guard_over;
    logic                 start_fail;
    logic                 stop_ok;
    logic                 stop_bad;

    assign take   = sample_valid && !sof_pulse;
    assign resync = sample_valid && sof_pulse;

    bpsk_phase_ref u_ref (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_sign  (sample_sign),
        .sof_pulse    (sof_pulse),
        .logic_bit    (logic_bit)
    );

    assign start_edge = (state == ST_GUARD) && take && !logic_bit;
    assign sym_adv    = take && ((state == ST_START) || (state == ST_DATA) ||
                                 (state == ST_STOP));

    bpsk_symbol_voter #(
        .SYM_SAMPLES (SYM_SAMPLES),
        .WIN_LO      (VOTE_LO),
        .WIN_LEN     (VOTE_LEN)
    ) u_voter (
        .clk      (clk),
        .rst      (rst),
        .restart  (start_edge),
        .advance  (sym_adv),
        .bit_in   (logic_bit),
        .sym_done (sym_done),
        .sym_bit  (sym_bit)
    );

    assign shift_en = (state == ST_DATA) && sym_done;

    bpsk_char_shifter #(
        .WIDTH (DATA_BITS)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_edge),
        .shift_en (shift_en),
        .bit_in   (sym_bit),
        .word     (word),
        .last_bit (last_bit)
    );

    // Events seen by the state machine and the output process
    assign guard_over = (state == ST_GUARD) && take && logic_bit &&
                        (ones_cnt == ONES_W'(ONES_LIMIT));
    assign start_fail = (state == ST_START) && sym_done && sym_bit;
    assign stop_ok    = (state == ST_STOP) && sym_done && sym_bit;
    assign stop_bad   = (state == ST_STOP) && sym_done && !sym_bit;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (resync) begin
            state_nxt = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_ARMED: begin
                    if (take && logic_bit) begin
                        state_nxt = ST_GUARD;
                    end
                end
                ST_GUARD: begin
                    if (start_edge) begin
                        state_nxt = ST_START;
                    end else if (guard_over) begin
                        state_nxt = ST_IDLE;
                    end
                end
                ST_START: begin
                    if (sym_done) begin
                        state_nxt = sym_bit ? ST_GUARD : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (sym_done && last_bit) begin
                        state_nxt = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (sym_done) begin
                        state_nxt = sym_bit ? ST_GUARD : ST_IDLE;
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // Outputs and the logic-1 run counter
    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt      <= '0;
            data_out      <= '0;
            data_valid    <= 1'b0;
            framing_error <= 1'b0;
        end else begin
            data_valid    <= stop_ok;
            framing_error <= guard_over || stop_bad;
            if (stop_ok) begin
                data_out <= word;
            end
            if (resync || start_fail) begin
                ones_cnt <= '0;
            end else if (stop_ok) begin
                ones_cnt <= ONES_W'(SYM_SAMPLES);
            end else if ((state == ST_ARMED) && take && logic_bit) begin
                ones_cnt <= ONES_W'(1);
            end else if ((state == ST_GUARD) && take && logic_bit && !guard_over) begin
                ones_cnt <= ones_cnt + ONES_W'(1);
            end
        end
    end

endmodule

// File: rtl/bpsk_char_deframer_chk.sv
module bpsk_char_deframer_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sample_valid,
    input logic                 sof_pulse,
    input logic [DATA_BITS-1:0] data_out,
    input logic                 data_valid,
    input logic                 framing_error
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid); // R3

    AST_DOUT_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_out) |-> data_valid); // R3

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        framing_error |=> !framing_error); // R12

    AST_NO_VALID_AND_ERR: assert property (@(posedge clk) disable iff (rst)
        !(data_valid && framing_error)); // R12

    AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $past(sample_valid && !sof_pulse)); // R10

    AST_ERR_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        framing_error |-> $past(sample_valid && !sof_pulse)); // R7

    AST_SOF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && sample_valid) |=> (!data_valid && !framing_error)); // R13

endmodule

bind bpsk_char_deframer bpsk_char_deframer_chk #(
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sample_valid  (sample_valid),
    .sof_pulse     (sof_pulse),
    .data_out      (data_out),
    .data_valid    (data_valid),
    .framing_error (framing_error)
);

// File: tb/bpsk_char_deframer_bench.sv
module bpsk_char_deframer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_valid = 1'b0;
    logic       sample_sign = 1'b0;
    logic       sof_pulse = 1'b0;
    logic [7:0] data_out;
    logic       data_valid;
    logic       framing_error;

    int n_checks = 0;
    int n_fail   = 0;
    int rx_n     = 0;
    int err_n    = 0;
    int both_n   = 0;
    logic [7:0] rx_bytes [16];
    logic tb_ref = 1'b0;
    logic tb_gap = 1'b0;

    always #4 clk = ~clk;

    bpsk_char_deframer u_bpsk_char_deframer (
        .clk           (clk),
        .rst           (rst),
        .sample_valid  (sample_valid),
        .sample_sign   (sample_sign),
        .sof_pulse     (sof_pulse),
        .data_out      (data_out),
        .data_valid    (data_valid),
        .framing_error (framing_error)
    );

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (data_valid) begin
                if (rx_n < 16) rx_bytes[rx_n] = data_out;
                rx_n++;
            end
            if (framing_error) err_n++;
            if (data_valid && framing_error) both_n++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        rx_n   = 0;
        err_n  = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sof_pulse    = 1'b0;
        end
    endtask

    task automatic put_logic(input logic b);
        if (tb_gap) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sof_pulse    = 1'b1;
            sample_sign  = ~(tb_ref ^ b);
        end
        @(negedge clk);
        sample_valid = 1'b1;
        sof_pulse    = 1'b0;
        sample_sign  = tb_ref ^ b;
    endtask

    task automatic sof(input logic r);
        @(negedge clk);
        sample_valid = 1'b1;
        sof_pulse    = 1'b1;
        sample_sign  = r;
        tb_ref       = r;
    endtask

    task automatic start_frame(input logic r);
        sof(r);
        repeat (8) put_logic(1'b1);
    endtask

    task automatic send_sym(input logic b);
        repeat (32) put_logic(b);
    endtask

    // ones_in_win samples of 1 at the start of the vote window, 0 for the rest of it, outside value elsewhere
    task automatic send_sym_vote(input int ones_in_win, input logic outside);
        for (int i = 0; i < 32; i++) begin
            if (i >= 8 && i <= 23) put_logic((i - 8) < ones_in_win);
            else                   put_logic(outside);
        end
    endtask

    task automatic send_char(input logic [7:0] b, input int guard);
        send_sym(1'b0);
        for (int i = 0; i < 8; i++) send_sym(b[i]);
        send_sym(1'b1);
        repeat (guard) put_logic(1'b1);
    endtask

    task automatic t_reset();
        chk("R1", "data_valid after reset", int'(data_valid), 0);
        chk("R1", "framing_error after reset", int'(framing_error), 0);
        chk("R1", "data_out after reset", int'(data_out), 0);
        clear_counts();
        tb_ref = 1'b0;
        repeat (8) put_logic(1'b1);
        send_char(8'h3C, 0);
        idle(3);
        chk("R1", "bytes before any SOF", rx_n, 0);
    endtask

    task automatic t_basic();
        clear_counts();
        start_frame(1'b0);
        send_char(8'hA5, 0);
        send_char(8'h3C, 0);
        idle(3);
        chk("R3", "byte count, guard 0", rx_n, 2);
        chk("R3", "first byte LSB first", int'(rx_bytes[0]), 'hA5);
        chk("R5", "second byte re-aligned", int'(rx_bytes[1]), 'h3C);
        chk("R3", "no error", err_n, 0);
    endtask

    task automatic t_inverted_guard();
        clear_counts();
        start_frame(1'b1);
        send_char(8'h01, 17);
        send_char(8'h80, 64);
        send_char(8'h42, 0);
        idle(3);
        chk("R2", "byte count, inverted reference", rx_n, 3);
        chk("R2", "byte 0x01 with reference 1", int'(rx_bytes[0]), 'h01);
        chk("R6", "byte after odd guard 17", int'(rx_bytes[1]), 'h80);
        chk("R6", "byte after maximum guard 64", int'(rx_bytes[2]), 'h42);
        chk("R6", "no error with legal guard", err_n, 0);
    endtask

    task automatic t_vote();
        clear_counts();
        start_frame(1'b0);
        send_sym(1'b0);
        send_sym_vote(8, 1'b1);   // tie -> 0, outside 1s ignored
        send_sym_vote(9, 1'b0);   // 9 of 16 -> 1
        send_sym(1'b1); send_sym(1'b0); send_sym(1'b1);
        send_sym(1'b0); send_sym(1'b1); send_sym(1'b0);
        send_sym(1'b1);
        idle(3);
        chk("R4", "byte count with vote edges", rx_n, 1);
        chk("R4", "vote tie 8 -> 0 and 9 -> 1", int'(rx_bytes[0]), 'h56);
    endtask

    task automatic t_stop_error();
        clear_counts();
        start_frame(1'b0);
        send_sym(1'b0);
        for (int i = 0; i < 8; i++) send_sym(i[0] ? 1'b0 : 1'b1);
        send_sym(1'b0);
        idle(3);
        chk("R8", "framing error on stop 0", err_n, 1);
        chk("R8", "no byte on stop 0", rx_n, 0);
        repeat (5) put_logic(1'b1);
        send_char(8'h11, 0);
        idle(3);
        chk("R8", "ignored after stop error", rx_n, 0);
    endtask

    task automatic t_overflow();
        clear_counts();
        start_frame(1'b1);
        send_char(8'h24, 0);
        repeat (64) put_logic(1'b1);
        idle(3);
        chk("R6", "96 ones accepted", err_n, 0);
        chk("R6", "byte before long run", int'(rx_bytes[0]), 'h24);
        put_logic(1'b1);
        idle(3);
        chk("R7", "97th one flags error", err_n, 1);
        send_char(8'h99, 0);
        idle(3);
        chk("R7", "ignored after overflow", rx_n, 1);
    endtask

    task automatic t_glitch();
        clear_counts();
        start_frame(1'b0);
        put_logic(1'b0);
        repeat (31) put_logic(1'b1);
        repeat (20) put_logic(1'b1);
        send_char(8'h9C, 0);
        idle(3);
        chk("R9", "glitch emits nothing extra", rx_n, 1);
        chk("R9", "byte after glitch", int'(rx_bytes[0]), 'h9C);
        chk("R9", "no error from glitch", err_n, 0);
    endtask

    task automatic t_gaps();
        clear_counts();
        start_frame(1'b1);
        tb_gap = 1'b1;
        send_char(8'hE1, 5);
        tb_gap = 1'b0;
        idle(3);
        chk("R10", "byte count with gaps", rx_n, 1);
        chk("R10", "byte with invalid cycles", int'(rx_bytes[0]), 'hE1);
        chk("R2", "sof with invalid sample ignored", err_n, 0);
    endtask

    task automatic t_armed();
        clear_counts();
        sof(1'b0);
        repeat (40) put_logic(1'b0);
        repeat (8) put_logic(1'b1);
        send_char(8'h5A, 0);
        idle(3);
        chk("R11", "byte count after leading zeros", rx_n, 1);
        chk("R11", "byte after leading zeros", int'(rx_bytes[0]), 'h5A);
    endtask

    task automatic t_resync();
        clear_counts();
        start_frame(1'b0);
        send_sym(1'b0);
        repeat (3) send_sym(1'b1);
        start_frame(1'b1);
        send_char(8'hC3, 0);
        idle(3);
        chk("R13", "partial char dropped", rx_n, 1);
        chk("R13", "byte after mid-char sof", int'(rx_bytes[0]), 'hC3);
        chk("R13", "no error on resync", err_n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_inverted_guard();
        t_vote();
        t_stop_error();
        t_overflow();
        t_glitch();
        t_gaps();
        t_armed();
        t_resync();
        chk("R12", "cycles with valid and error together", both_n, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog: actual=150000 cycles expected=fewer");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule